// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Committed Settings

This block produces four independent pulse-width modulated outputs. Each channel has three settings: a prescaler that stretches every count step, a period divider that sets how many steps make up one period, and a high-duration value that sets how many steps the pin stays high at the start of each period. Software programs the channels through a small register window. It uses a word address, 32-bit write data with a write strobe, and read data returned combinationally for the addressed word.

Settings written by software go into a pending copy. They reach the running waveform only when software sets the commit bit, and even then only at the next period boundary. A period that has started is therefore never shortened or reshaped. Clearing the run bit is graceful: the channel finishes its current period, parks its output low, and returns its prescaler and divider to their defaults. The register window is control traffic, not a data stream, so it carries no valid/ready handshake: every write is accepted on the clock edge where the strobe is high.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low, every channel word 0 reads 0x0000_0001 (divider 1, high duration 0), and every channel word 1 reads 0.
- R2: Channel i is reached at word addresses 2i and 2i+1. Word 0 holds high duration in bits [31:16] and divider in bits [15:0]. Word 1 holds run in bit 31, commit in bit 30 and prescaler in bits [15:0]; its other bits read 0. Reads return the active settings, not the pending ones.
- R3: A running channel repeats a period of (divider+1)*(prescaler+1) clocks. The output is high for the first high*(prescaler+1) clocks of each period and low for the rest. A high duration of at least divider+1 keeps the output high all period, and a high duration of 0 keeps it low.
- R4: On an idle channel, a word 1 write that sets both run and commit loads the pending settings on the next edge. That edge starts the first period, so the output is high in the cycle after it when the high duration is nonzero.
- R5: On an idle channel, setting run without commit leaves the output low and starts no period.
- R6: Writes to a running channel do not change its active settings or its waveform before the current period ends. A pending commit replaces them exactly at the period boundary.
- R7: The commit bit reads 1 from the edge on which it is written until the edge on which the pending settings are loaded, and reads 0 afterwards.
- R8: When run is cleared on a running channel, the current period completes unchanged and the output then stays low.
- R9: When a channel stops after a disable, its prescaler reads 0, its divider reads 1, its high duration is kept, and any uncommitted update is discarded.
- R10: Word addresses with no channel read as 0, and writes to them change no register and no output.
- R11: Each channel's output depends only on its own registers: programming one channel leaves the other outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at reg_addr |
| pwm_out | output | NUM_CH | One waveform output per channel |

## Verification
The hardest case to reach is a commit that arrives in the middle of a running period. The first half of the waveform must keep the old shape and the second half must take the new one, with the split on exactly the right edge. The bench starts a channel from idle so that it knows the phase of every cycle. It then drives the register writes on chosen sample indices inside the loop that checks the waveform, and reads the commit bit and the active words on both sides of the boundary. Graceful disable uses the same method, clearing run early in a period and expecting the remaining high and low cycles before the output parks.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int CNT_W   = 16;
  localparam int WORD_W  = 32;
  localparam int RUN_BIT = 31;
  localparam int CMT_BIT = 30;
  localparam int HI_LSB  = 16;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] pre;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_DEFAULT = '{hi: '0, div: CNT_W'(1), pre: '0};

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] pre,
  input  logic [W-1:0] div,
  output logic [W-1:0] step,
  output logic         last
);

  logic [W-1:0] tick_q;
  logic [W-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      step_q <= '0;
    end else if (restart) begin
      tick_q <= '0;
      step_q <= '0;
    end else if (run) begin
      if (tick_q == pre) begin
        tick_q <= '0;
        step_q <= (step_q == div) ? '0 : step_q + W'(1);
      end else begin
        tick_q <= tick_q + W'(1);
      end
    end
  end

  assign step = step_q;
  assign last = run && (tick_q == pre) && (step_q == div);

  // R3: counters never leave the range set by the active settings
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tick_q <= pre && step_q <= div));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word0,
  input  logic              wr_word1,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word0,
  output logic [WORD_W-1:0] rd_word1,
  output logic              pwm_o
);

  chan_cfg_t        pend_q;
  chan_cfg_t        act_q;
  logic             run_en_q;
  logic             cmt_q;
  logic             active_q;
  logic [CNT_W-1:0] step;
  logic             last;
  logic             stop;
  logic             load;
  logic             set_cmt;

  assign stop    = active_q && last && !run_en_q;
  assign load    = cmt_q && !stop && (active_q ? last : run_en_q);
  assign set_cmt = wr_word1 && wdata[CMT_BIT];

  pwm_timebase #(.W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load && !active_q),
    .run     (active_q),
    .pre     (act_q.pre),
    .div     (act_q.div),
    .step    (step),
    .last    (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= CFG_DEFAULT;
      act_q    <= CFG_DEFAULT;
      run_en_q <= 1'b0;
      cmt_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (stop) begin
        active_q  <= 1'b0;
        act_q.pre <= '0;
        act_q.div <= CNT_W'(1);
        cmt_q     <= 1'b0;
      end else if (load) begin
        act_q    <= pend_q;
        active_q <= 1'b1;
        cmt_q    <= 1'b0;
      end
      if (wr_word0) begin
        pend_q.hi  <= wdata[HI_LSB +: CNT_W];
        pend_q.div <= wdata[CNT_W-1:0];
      end
      if (wr_word1) begin
        pend_q.pre <= wdata[CNT_W-1:0];
        run_en_q   <= wdata[RUN_BIT];
      end
      if (set_cmt) cmt_q <= 1'b1;
    end
  end

  assign pwm_o    = active_q && (step < act_q.hi);
  assign rd_word0 = {act_q.hi, act_q.div};
  assign rd_word1 = {run_en_q, cmt_q, (WORD_W-CNT_W-2)'(0), act_q.pre};

  // R6: active settings hold for the whole period
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !last) |=> $stable(act_q));

  // R7: a consumed commit clears unless rewritten on the same edge
  assert_cmt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !set_cmt) |=> !cmt_q);

  // R9: a stopped channel holds default prescaler and divider
  assert_stop_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> (act_q.pre == '0 && act_q.div == CNT_W'(1)));

  // R4: run plus commit on an idle channel starts on the next edge
  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && run_en_q && cmt_q) |=> active_q);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int SEL_W = ADDR_W - 1;

  logic [SEL_W-1:0]  ch_sel;
  logic              mapped;
  logic [WORD_W-1:0] rd0_a [NUM_CH];
  logic [WORD_W-1:0] rd1_a [NUM_CH];

  assign ch_sel = reg_addr[ADDR_W-1:1];
  assign mapped = (int'(ch_sel) < NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = reg_wr_en && mapped && (ch_sel == SEL_W'(g));

    pwm_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_word0 (hit && !reg_addr[0]),
      .wr_word1 (hit && reg_addr[0]),
      .wdata    (reg_wdata),
      .rd_word0 (rd0_a[g]),
      .rd_word1 (rd1_a[g]),
      .pwm_o    (pwm_out[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (mapped && ch_sel == SEL_W'(i))
        reg_rdata = reg_addr[0] ? rd1_a[i] : rd0_a[i];
    end
  end

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pwm_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = 4'(a);
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_wr_en = 1'b0;
    reg_addr  = 4'(a);
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1;
    int idx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 and R2: reset state of every channel word
    chk("R1 outputs", 32'(pwm_out), 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(2*c, r0);   chk("R1 word0", r0, 32'h0000_0001);
      rd(2*c+1, r1); chk("R1 word1", r1, 32'h0);
    end

    // R10: writes to unmapped words are dropped, reads return 0
    for (int a = 8; a < 16; a++) wr(a, 32'hFFFF_FFFF);
    for (int a = 8; a < 16; a++) begin
      rd(a, r0); chk("R10 unmapped read", r0, 32'h0);
    end
    for (int c = 0; c < 4; c++) begin
      rd(2*c, r0);   chk("R10 word0 untouched", r0, 32'h0000_0001);
      rd(2*c+1, r1); chk("R10 word1 untouched", r1, 32'h0);
    end
    chk("R10 outputs", 32'(pwm_out), 32'h0);
    // commit channel 0 with only word 1: pending word 0 must still be default
    wr(1, 32'hC000_0000);
    @(negedge clk);
    rd(0, r0); chk("R10 pending untouched", r0, 32'h0000_0001);
    chk("R10 output low with hi=0", 32'(pwm_out), 32'h0);
    wr(1, 32'h0);
    repeat (6) @(negedge clk);

    // R5: run without commit on an idle channel
    wr(6, {16'd1, 16'd1});
    wr(7, 32'h8000_0000);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R5 idle stays low", 32'(pwm_out), 32'h0);
    end
    rd(7, r1); chk("R5 word1 readback", r1, 32'h8000_0000);
    wr(7, 32'h0);

    // R3 R4 R9 R11: sweep prescaler, divider and high duration
    idx = 0;
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 4; d++) begin
        for (int h = 0; h < 6; h++) begin
          int ch, per, bad;
          logic [3:0] bad_act, bad_exp;
          ch = idx % 4;
          idx++;
          wr(2*ch, {16'(h), 16'(d)});
          wr(2*ch+1, 32'hC000_0000 | 32'(p));
          per = (d + 1) * (p + 1);
          bad = 0;
          bad_act = '0;
          bad_exp = '0;
          for (int j = 0; j < 2*per; j++) begin
            logic [3:0] ev;
            @(negedge clk);
            ev = (((j % per) / (p + 1)) < h) ? (4'b1 << ch) : 4'b0;
            if (pwm_out !== ev) begin
              if (bad == 0) begin bad_act = pwm_out; bad_exp = ev; end
              bad++;
            end
          end
          chk($sformatf("R3 R4 R11 wave p=%0d d=%0d h=%0d", p, d, h),
              32'(bad_act), 32'(bad_exp));
          wr(2*ch+1, 32'h0);
          repeat (2*per + 2) @(negedge clk);
          rd(2*ch, r0);
          rd(2*ch+1, r1);
          chk("R9 stop defaults", {r0, r1}, {16'(h), 16'd1, 32'h0});
          chk("R8 parked low", 32'(pwm_out), 32'h0);
        end
      end
    end

    // R6 R7: commit in the middle of a running period on channel 1
    wr(2, {16'd2, 16'd3});
    wr(3, 32'hC000_0001);
    for (int j = 0; j < 14; j++) begin
      logic ev;
      @(negedge clk);
      if (j < 8) ev = (j / 2) < 2;
      else       ev = ((j - 8) % 2) == 0;
      chk($sformatf("R6 wave j=%0d", j), 32'(pwm_out), 32'(ev) << 1);
      if (j == 2) begin reg_addr = 4'd2; reg_wdata = {16'd1, 16'd1}; reg_wr_en = 1'b1; end
      if (j == 3) begin reg_addr = 4'd3; reg_wdata = 32'hC000_0000; reg_wr_en = 1'b1; end
      if (j == 4) reg_wr_en = 1'b0;
      if (j == 5) begin
        rd(3, r1); chk("R7 commit pending", r1, 32'hC000_0001);
        rd(2, r0); chk("R6 old active kept", r0, 32'h0002_0003);
      end
      if (j == 9) begin
        rd(3, r1); chk("R7 commit cleared", r1, 32'h8000_0000);
        rd(2, r0); chk("R6 new active", r0, 32'h0001_0001);
      end
    end
    wr(3, 32'h0);
    repeat (6) @(negedge clk);
    chk("R8 ch1 parked", 32'(pwm_out), 32'h0);

    // R8 R9: graceful disable early in a period on channel 2
    wr(4, {16'd2, 16'd4});
    wr(5, 32'hC000_0000);
    for (int j = 0; j < 10; j++) begin
      logic ev;
      @(negedge clk);
      ev = (j < 5) ? (j < 2) : 1'b0;
      chk($sformatf("R8 finish j=%0d", j), 32'(pwm_out), 32'(ev) << 2);
      if (j == 1) begin reg_addr = 4'd5; reg_wdata = 32'h0; reg_wr_en = 1'b1; end
      if (j == 2) reg_wr_en = 1'b0;
    end
    rd(4, r0); chk("R9 word0 after stop", r0, 32'h0002_0001);
    rd(5, r1); chk("R9 word1 after stop", r1, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule